// File: doc/BRIEF.md
# Convolution Tap Mask Analyzer

This block examines a programmable 3x3 mask of signed 8-bit coefficients and finds out how many different weight values it contains. Pixels under window positions that carry the same weight can be added together before a single multiply. The number of distinct values is therefore the number of multipliers one output pixel needs. Any reprogrammed mask can be analysed this way at run time, so the count is not fixed at nine.

Software or a sequencer writes the nine coefficients onto `maskIn` and pulses `loadStrobe`. The block captures the mask and walks positions 0 to 8 in raster order, one per clock. The result has three parts. A table holds each distinct value in the order it was first seen. A map gives each window position its group index. A count gives the number of groups. `done` marks when all three are final. A new strobe at any time throws away the scan in progress and starts again.

Top module: `tap_mask_analyzer`

## Requirements
- R1: After reset, `done` is 0, `uniqueCount` is 0, and `uniqueVals` and `groupMap` are all zeros.
- R2: In the cycle after `loadStrobe` is sampled high, `done` is 0, `uniqueCount` is 0, and `uniqueVals` and `groupMap` are all zeros.
- R3: `done` rises on the 9th rising edge after the edge that samples `loadStrobe`. It stays high, with all outputs unchanged, until the next load.
- R4: When `done` is 1, `uniqueCount` equals the number of distinct 8-bit two's complement values among the nine coefficients, so it lies in 1..9. Examples: a uniform mask gives 1, and a mask with one centre value and a different value everywhere else gives 2.
- R5: A coefficient of zero counts as a distinct value like any other. A mask of -1/0/+1 columns gives 3, and the -2..+2 edge mask gives 5.
- R6: Groups are numbered in raster order of first appearance. Position 0 is always group 0, and each value not seen before takes the next free index. Entry g of `uniqueVals` holds the value of group g, at bits [8g+7:8g].
- R7: When `done` is 1, the group field of position p (`groupMap` bits [4p+3:4p], with p = row*3+col) names the table entry that equals coefficient p. Coefficient p is `maskIn` bits [8p+7:8p].
- R8: When `done` is 1, every table entry at an index of `uniqueCount` or higher reads zero.
- R9: A load that arrives during a scan aborts it. The result then describes the newest mask, and `done` follows the R3 timing from that newest load.
- R10: Changes on `maskIn` while `loadStrobe` is low have no effect on the scan or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadStrobe | input | 1 | Captures `maskIn` and restarts the scan |
| maskIn | input | 72 | Nine signed coefficients, position p at [8p+7:8p] |
| done | output | 1 | Result complete |
| uniqueCount | output | 4 | Number of distinct coefficient values |
| uniqueVals | output | 72 | Table of distinct values, group g at [8g+7:8g] |
| groupMap | output | 36 | Group index per position, position p at [4p+3:4p] |

## Verification
A bad group index or a stale table entry reaches the ports within the nine scan cycles. The bench compares the map, the table and the count against a reference, so such a fault shows up at the first `done` after the load. A slip in the position counter shows up as `done` rising one edge early or late, or as a position whose map field is left at zero. Faults in the abort path only show when a second load lands partway through a scan. Such a fault leaves an entry from the first mask in the table, which the count or the zero-fill check on unused entries reports as soon as `done` rises.

// File: rtl/tma_pkg.sv
package tma_pkg;
  parameter int NUM_TAPS = 9;
  parameter int COEF_W   = 8;
  localparam int IDX_W   = $clog2(NUM_TAPS);
  localparam int CNT_W   = $clog2(NUM_TAPS + 1);

  typedef struct packed {
    logic             capture;
    logic             step;
    logic [IDX_W-1:0] pos;
  } ctrlStrobe_t;
endpackage

// File: rtl/tma_ctrl.sv
module tma_ctrl
  import tma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadStrobe,
  output ctrlStrobe_t strobes,
  output logic        done
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(NUM_TAPS - 1);

  typedef enum logic {IDLE, SCAN} state_t;
  state_t           stateQ;
  logic [IDX_W-1:0] posQ;

  always_comb begin
    strobes.capture = loadStrobe;
    strobes.step    = (stateQ == SCAN) && !loadStrobe;
    strobes.pos     = posQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= IDLE;
      posQ   <= '0;
      done   <= 1'b0;
    end else if (loadStrobe) begin
      stateQ <= SCAN;
      posQ   <= '0;
      done   <= 1'b0;
    end else if (stateQ == SCAN) begin
      if (posQ == LAST_POS) begin
        stateQ <= IDLE;
        posQ   <= '0;
        done   <= 1'b1;
      end else begin
        posQ <= posQ + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tma_datapath.sv
module tma_datapath
  import tma_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobes,
  input  logic [NUM_TAPS*COEF_W-1:0] maskIn,
  output logic [CNT_W-1:0]           uniqueCount,
  output logic [NUM_TAPS*COEF_W-1:0] uniqueVals,
  output logic [NUM_TAPS*IDX_W-1:0]  groupMap
);
  logic [COEF_W-1:0] maskQ [NUM_TAPS];
  logic [COEF_W-1:0] valsQ [NUM_TAPS];
  logic [IDX_W-1:0]  mapQ  [NUM_TAPS];
  logic [CNT_W-1:0]  countQ;

  logic [COEF_W-1:0]   curCoef;
  logic [NUM_TAPS-1:0] hit;
  logic                anyHit;
  logic [IDX_W-1:0]    hitIdx;

  assign curCoef = maskQ[strobes.pos];

  for (genvar i = 0; i < NUM_TAPS; i++) begin : gHit
    assign hit[i] = (CNT_W'(i) < countQ) && (valsQ[i] == curCoef);
  end

  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int i = NUM_TAPS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      for (int i = 0; i < NUM_TAPS; i++) begin
        maskQ[i] <= '0;
        valsQ[i] <= '0;
        mapQ[i]  <= '0;
      end
    end else if (strobes.capture) begin
      countQ <= '0;
      for (int i = 0; i < NUM_TAPS; i++) begin
        maskQ[i] <= maskIn[i*COEF_W +: COEF_W];
        valsQ[i] <= '0;
        mapQ[i]  <= '0;
      end
    end else if (strobes.step) begin
      if (anyHit) begin
        mapQ[strobes.pos] <= hitIdx;
      end else begin
        valsQ[countQ[IDX_W-1:0]] <= curCoef;
        mapQ[strobes.pos]        <= countQ[IDX_W-1:0];
        countQ                   <= countQ + 1'b1;
      end
    end
  end

  assign uniqueCount = countQ;
  for (genvar i = 0; i < NUM_TAPS; i++) begin : gOut
    assign uniqueVals[i*COEF_W +: COEF_W] = valsQ[i];
    assign groupMap[i*IDX_W +: IDX_W]     = mapQ[i];
  end
endmodule

// File: rtl/tap_mask_analyzer.sv
module tap_mask_analyzer
  import tma_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       loadStrobe,
  input  logic [NUM_TAPS*COEF_W-1:0] maskIn,
  output logic                       done,
  output logic [CNT_W-1:0]           uniqueCount,
  output logic [NUM_TAPS*COEF_W-1:0] uniqueVals,
  output logic [NUM_TAPS*IDX_W-1:0]  groupMap
);
  ctrlStrobe_t strobes;

  tma_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadStrobe (loadStrobe),
    .strobes    (strobes),
    .done       (done)
  );

  tma_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .maskIn      (maskIn),
    .uniqueCount (uniqueCount),
    .uniqueVals  (uniqueVals),
    .groupMap    (groupMap)
  );
endmodule

// File: rtl/tma_checker.sv
module tma_checker
  import tma_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       loadStrobe,
  input logic                       done,
  input logic [CNT_W-1:0]           uniqueCount,
  input logic [NUM_TAPS*COEF_W-1:0] uniqueVals,
  input logic [NUM_TAPS*IDX_W-1:0]  groupMap
);
  assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> (!done && uniqueCount == '0 && uniqueVals == '0 && groupMap == '0));

  assert_done_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !loadStrobe) |=> (done && $stable(uniqueCount) && $stable(uniqueVals) && $stable(groupMap)));

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (uniqueCount >= CNT_W'(1) && uniqueCount <= CNT_W'(NUM_TAPS)));

  assert_count_grows_R4: assert property (@(posedge clk) disable iff (!rstN)
    !loadStrobe |=> (uniqueCount >= $past(uniqueCount)));

  assert_first_group_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (groupMap[IDX_W-1:0] == '0));

  for (genvar p = 0; p < NUM_TAPS; p++) begin : gMap
    assert_map_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
      done |-> (CNT_W'(groupMap[p*IDX_W +: IDX_W]) < uniqueCount));
    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
      (done && CNT_W'(p) >= uniqueCount) |-> (uniqueVals[p*COEF_W +: COEF_W] == '0));
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : gPairA
    for (genvar j = i + 1; j < NUM_TAPS; j++) begin : gPairB
      assert_distinct_R4: assert property (@(posedge clk) disable iff (!rstN)
        (done && CNT_W'(j) < uniqueCount) |->
          (uniqueVals[i*COEF_W +: COEF_W] != uniqueVals[j*COEF_W +: COEF_W]));
    end
  end
endmodule

bind tap_mask_analyzer tma_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .loadStrobe  (loadStrobe),
  .done        (done),
  .uniqueCount (uniqueCount),
  .uniqueVals  (uniqueVals),
  .groupMap    (groupMap)
);

// File: tb/tb_tap_mask_analyzer.sv
module tb_tap_mask_analyzer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [71:0] maskIn = '0;
  logic        done;
  logic [3:0]  uniqueCount;
  logic [71:0] uniqueVals;
  logic [35:0] groupMap;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  tap_mask_analyzer dut (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .maskIn(maskIn),
    .done(done), .uniqueCount(uniqueCount), .uniqueVals(uniqueVals), .groupMap(groupMap)
  );

  function automatic logic [71:0] mk(int a, int b, int c, int d, int e, int f, int g, int h, int i);
    int v[9];
    logic [71:0] r;
    v = '{a, b, c, d, e, f, g, h, i};
    r = '0;
    for (int k = 0; k < 9; k++) r[k*8 +: 8] = 8'(v[k]);
    return r;
  endfunction

  localparam int NVEC = 6;
  localparam logic [71:0] VEC_MASK [NVEC] = '{
    mk( 1,  1,  1,  1,  1,  1,  1,  1,  1),
    mk(-1, -1, -1, -1,  8, -1, -1, -1, -1),
    mk(-1,  0,  1, -1,  0,  1, -1,  0,  1),
    mk(-1,  0,  1, -2,  0,  2, -1,  0,  1),
    mk(-128, 127, 0, 1, -1, 2, -2, 3, 4),
    mk( 0,  0,  0,  0,  0,  0,  0,  0,  0)
  };
  localparam int VEC_CNT [NVEC] = '{1, 2, 3, 5, 9, 1};
  localparam string VEC_REQ [NVEC] = '{"R4", "R4", "R5", "R5", "R4", "R5"};

  logic [3:0]  refCnt;
  logic [71:0] refVals;
  logic [35:0] refMap;

  // Reference: first-seen raster order grouping (R6, R7, R8)
  task automatic buildRef(input logic [71:0] m);
    logic found;
    refCnt = 0; refVals = '0; refMap = '0;
    for (int p = 0; p < 9; p++) begin
      found = 1'b0;
      for (int g = 0; g < 9; g++) begin
        if (!found && g < int'(refCnt) && refVals[g*8 +: 8] == m[p*8 +: 8]) begin
          refMap[p*4 +: 4] = 4'(g);
          found = 1'b1;
        end
      end
      if (!found) begin
        refVals[int'(refCnt)*8 +: 8] = m[p*8 +: 8];
        refMap[p*4 +: 4] = refCnt;
        refCnt = refCnt + 1'b1;
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseLoad(input logic [71:0] m);
    @(negedge clk);
    loadStrobe = 1'b1;
    maskIn = m;
    @(negedge clk);
    loadStrobe = 1'b0;
    maskIn = ~m;                       // R10: later changes must be ignored
  endtask

  task automatic checkResult(input logic [71:0] m, input string req);
    buildRef(m);
    check(uniqueCount == refCnt, req, 72'(uniqueCount), 72'(refCnt));
    check(uniqueVals == refVals, "R6/R8", uniqueVals, refVals);
    check(groupMap == refMap, "R7", 72'(groupMap), 72'(refMap));
  endtask

  // Load, then verify clear, exact done timing and the result
  task automatic runMask(input logic [71:0] m, input string req);
    pulseLoad(m);
    check(!done && uniqueCount == 0 && uniqueVals == '0 && groupMap == '0, "R2",
          {uniqueVals[70:0], done}, 72'(0));
    repeat (8) @(negedge clk);
    check(done == 1'b0, "R3 early", 72'(done), 72'(0));
    @(negedge clk);
    check(done == 1'b1, "R3 late", 72'(done), 72'(1));
    checkResult(m, req);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [71:0] a;
    logic [71:0] b;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && uniqueCount == 0 && uniqueVals == '0 && groupMap == '0, "R1",
          {uniqueVals[70:0], done}, 72'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(!done && uniqueCount == 0, "R1", 72'(done), 72'(0));

    for (int v = 0; v < NVEC; v++) begin
      runMask(VEC_MASK[v], VEC_REQ[v]);
      check(uniqueCount == 4'(VEC_CNT[v]), VEC_REQ[v], 72'(uniqueCount), 72'(VEC_CNT[v]));
    end

    // R3: result holds while idle, maskIn toggling (R10)
    a = mk(3, -3, 3, 5, -3, 5, 7, 7, 3);
    runMask(a, "R4");
    repeat (15) begin
      @(negedge clk);
      maskIn = maskIn + 72'h0101;
    end
    check(done == 1'b1, "R3 hold", 72'(done), 72'(1));
    checkResult(a, "R10");
    check(groupMap[3:0] == 4'd0, "R6", 72'(groupMap[3:0]), 72'(0));

    // R9: abort mid-scan
    b = mk(9, 9, 4, 4, 0, 0, -9, -9, 9);
    pulseLoad(a);
    repeat (4) @(negedge clk);
    runMask(b, "R9");

    // R9: reload on the last scan cycle
    pulseLoad(a);
    repeat (7) @(negedge clk);
    runMask(VEC_MASK[3], "R9");

    // R2: load while done drops done next cycle
    pulseLoad(a);
    check(done == 1'b0, "R2", 72'(done), 72'(0));
    repeat (9) @(negedge clk);
    checkResult(a, "R4");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule